// File: doc/BRIEF.md
# Banked Memory Map Controller

This block sits between an 8-bit CPU and the memory arrays of a 64 KB address space. For every memory access it works out which device the address belongs to. The devices are a low ROM, a high ROM, the base RAM array and a two-bank expansion array. The block raises one chip select, gives the offset inside that device, and passes the write strobe on only when the write is allowed. The arrays themselves are outside the block.

One 8-bit system-control register, written through an I/O port, sets the routing:

- **Shadow** (bit 0, active low): maps the start of the high ROM over the bottom 2 KB so that the CPU boots from it.
- **Protect** (bit 1): makes the 16 KB region at 0x4000 read-only.
- **Expand** (bit 2): opens the expansion window at 0x8000.
- **Bank** (bit 3): picks which expansion bank the window maps.
- **Caps** (bit 5): drives the caps-lock lamp.

A second I/O address is a read-only status port. It gathers keyboard, cartridge, auxiliary and serial-line levels with the protect and expand flags.

Memory routing is purely combinational from the access pins and the stored control value. A write to the control register lands on the clock edge, so the access presented in the next cycle already obeys it. The CPU side is a plain request/strobe bus with no valid/ready back-pressure, because every access completes in the cycle it is presented.

Top module: `memmap_ctrl`

## Requirements
- R1: At most one of `sel_lorom`, `sel_hirom`, `sel_ram`, `sel_exp` is high at any time. With `mem_req` low, or when an access is dropped, all four are low, `dev_addr` is 0 and `dev_we` is low.
- R2: After reset the control register is 0x00, so shadow is on and `caps_led` is low. A read at 0x0000 then selects the high ROM at offset 0x0000.
- R3: With control bit 0 at 0 (shadow on), a read in 0x0000–0x07FF selects the high ROM at offset `addr[10:0]`, and a write there is dropped. With bit 0 at 1, reads there select the low ROM at offset `addr[10:0]`.
- R4: With control bit 1 set, a write in 0x4000–0x7FFF is dropped. Reads there, and all accesses with bit 1 clear, go to the base RAM at offset `addr`.
- R5: With control bit 2 set, accesses in 0x8000–0xBFFF select the expansion array at offset `{bit3, addr[13:0]}`, and writes there raise `dev_we`. With bit 2 clear, they go to the base RAM at offset `addr`.
- R6: Accesses in 0x0800–0x3FFF go to the base RAM at offset `addr`. Reads in 0xC000–0xFFFF select the high ROM at offset `addr[13:0]`. Writes to either ROM, in any mode, are dropped.
- R7: An I/O write to port 0xFF loads the control register at that clock edge. The new value routes the access presented in the next cycle, while an access in the same cycle still uses the old value. `caps_led` follows control bit 5.
- R8: An I/O read of port 0x03 returns the status byte, laid out as follows. At any other I/O address, or with `io_rd_en` low, `io_rdata` is 0x00.

  | Bit | Meaning |
  |---|---|
  | 0 | shift |
  | 1 | protect flag |
  | 2 | expand flag |
  | 3 | cartridge |
  | 4 | any key |
  | 5 | auxiliary |
  | 6 | inverse of any key |
  | 7 | serial receive level |

- R9: An I/O write to any address other than 0xFF leaves the control register, and so the routing, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_wr_en | input | 1 | I/O write strobe |
| io_rd_en | input | 1 | I/O read strobe |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (status port) |
| mem_req | input | 1 | Memory access present this cycle |
| mem_we | input | 1 | Access is a write |
| mem_addr | input | 16 | CPU memory address |
| sel_lorom | output | 1 | Low ROM chip select |
| sel_hirom | output | 1 | High ROM chip select |
| sel_ram | output | 1 | Base RAM chip select |
| sel_exp | output | 1 | Expansion array chip select |
| dev_addr | output | 16 | Offset inside the selected device |
| dev_we | output | 1 | Write strobe to the selected device |
| caps_led | output | 1 | Caps-lock lamp |
| st_shift | input | 1 | Shift key level |
| st_anykey | input | 1 | Any key pressed |
| st_cart | input | 1 | Cartridge present |
| st_aux | input | 1 | Auxiliary signal |
| st_rx | input | 1 | Serial receive level |

## Verification
The hardest case to reach is the cycle where a control-register write and a memory access arrive together. The access must still route with the old value, and only the following access may see the new one. The stimulus puts these two in the same cycle several times, at each mode change: shadow off, protect on, window on, bank flip. It then repeats the same address in the next cycle, so both sides of the boundary are compared. Combined settings are also reached, such as protect with the window open on bank 1, and each is swept across every region edge.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  // control register bit positions (decoded by software, so they are fixed)
  localparam int CB_SHADOW_N = 0;
  localparam int CB_PROTECT  = 1;
  localparam int CB_EXPAND   = 2;
  localparam int CB_BANK     = 3;
  localparam int CB_CAPS     = 5;

  typedef enum logic [2:0] {
    RG_LOROM,
    RG_RAM,
    RG_PROT,
    RG_WIN,
    RG_HIROM
  } region_e;

  typedef struct packed {
    logic caps;
    logic bank;
    logic expand;
    logic protect;
    logic shadow_on;
  } ctrl_t;

  function automatic ctrl_t unpack_ctrl(input logic [7:0] v);
    ctrl_t c;
    c.shadow_on = ~v[CB_SHADOW_N];
    c.protect   = v[CB_PROTECT];
    c.expand    = v[CB_EXPAND];
    c.bank      = v[CB_BANK];
    c.caps      = v[CB_CAPS];
    return c;
  endfunction

endpackage

// File: rtl/memmap_ctrl_reg.sv
module memmap_ctrl_reg #(
  parameter int DW = 8,
  parameter logic [DW-1:0] RESET_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RESET_VAL;
    else if (load) q <= wdata;
  end

endmodule

// File: rtl/memmap_region_dec.sv
module memmap_region_dec
  import memmap_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] RAM_BASE  = 16'h0800,
  parameter logic [AW-1:0] PROT_BASE = 16'h4000,
  parameter logic [AW-1:0] WIN_BASE  = 16'h8000,
  parameter logic [AW-1:0] HROM_BASE = 16'hC000
) (
  input  logic [AW-1:0] addr,
  output region_e       region
);

  always_comb begin
    if (addr >= HROM_BASE)      region = RG_HIROM;
    else if (addr >= WIN_BASE)  region = RG_WIN;
    else if (addr >= PROT_BASE) region = RG_PROT;
    else if (addr >= RAM_BASE)  region = RG_RAM;
    else                        region = RG_LOROM;
  end

endmodule

// File: rtl/memmap_route.sv
module memmap_route
  import memmap_pkg::*;
#(
  parameter int AW     = 16,
  parameter int LO_W   = 11,
  parameter int HROM_W = 14,
  parameter int WIN_W  = 14
) (
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  region_e       region,
  input  ctrl_t         ctrl,
  output logic [3:0]    sel,       // {exp, ram, hirom, lorom}
  output logic [AW-1:0] dev_addr,
  output logic          dev_we
);

  localparam int SEL_LO  = 0;
  localparam int SEL_HI  = 1;
  localparam int SEL_RAM = 2;
  localparam int SEL_EXP = 3;

  logic [AW-1:0] lo_off, hi_off, win_off;

  assign lo_off  = AW'(addr[LO_W-1:0]);
  assign hi_off  = AW'(addr[HROM_W-1:0]);
  assign win_off = AW'({ctrl.bank, addr[WIN_W-1:0]});

  always_comb begin
    sel      = '0;
    dev_addr = '0;
    dev_we   = 1'b0;
    if (req) begin
      unique case (region)
        RG_LOROM: begin
          if (!we) begin
            if (ctrl.shadow_on) sel[SEL_HI] = 1'b1;
            else                sel[SEL_LO] = 1'b1;
            dev_addr = lo_off;
          end
        end
        RG_RAM: begin
          sel[SEL_RAM] = 1'b1;
          dev_addr     = addr;
          dev_we       = we;
        end
        RG_PROT: begin
          if (!(we && ctrl.protect)) begin
            sel[SEL_RAM] = 1'b1;
            dev_addr     = addr;
            dev_we       = we;
          end
        end
        RG_WIN: begin
          if (ctrl.expand) begin
            sel[SEL_EXP] = 1'b1;
            dev_addr     = win_off;
          end else begin
            sel[SEL_RAM] = 1'b1;
            dev_addr     = addr;
          end
          dev_we = we;
        end
        RG_HIROM: begin
          if (!we) begin
            sel[SEL_HI] = 1'b1;
            dev_addr    = hi_off;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/memmap_status.sv
module memmap_status (
  input  logic       shift,
  input  logic       protect,
  input  logic       expand,
  input  logic       cart,
  input  logic       anykey,
  input  logic       aux,
  input  logic       rx,
  output logic [7:0] status
);

  assign status = {rx, ~anykey, aux, anykey, cart, expand, protect, shift};

endmodule

// File: rtl/memmap_ctrl.sv
module memmap_ctrl
  import memmap_pkg::*;
#(
  parameter int DW   = 8,
  parameter int IOAW = 8,
  parameter int AW   = 16,
  parameter logic [IOAW-1:0] CTRL_PORT = 8'hFF,
  parameter logic [IOAW-1:0] STAT_PORT = 8'h03
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            io_wr_en,
  input  logic            io_rd_en,
  input  logic [IOAW-1:0] io_addr,
  input  logic [DW-1:0]   io_wdata,
  output logic [DW-1:0]   io_rdata,
  input  logic            mem_req,
  input  logic            mem_we,
  input  logic [AW-1:0]   mem_addr,
  output logic            sel_lorom,
  output logic            sel_hirom,
  output logic            sel_ram,
  output logic            sel_exp,
  output logic [AW-1:0]   dev_addr,
  output logic            dev_we,
  output logic            caps_led,
  input  logic            st_shift,
  input  logic            st_anykey,
  input  logic            st_cart,
  input  logic            st_aux,
  input  logic            st_rx
);

  logic [DW-1:0] ctrl_q;
  ctrl_t         ctrl;
  region_e       region;
  logic [3:0]    sel;
  logic [7:0]    status;
  logic          ctrl_load;

  assign ctrl_load = io_wr_en && (io_addr == CTRL_PORT);

  memmap_ctrl_reg #(.DW(DW)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ctrl_load),
    .wdata (io_wdata),
    .q     (ctrl_q)
  );

  assign ctrl = unpack_ctrl(ctrl_q[7:0]);

  memmap_region_dec #(.AW(AW)) u_dec (
    .addr   (mem_addr),
    .region (region)
  );

  memmap_route #(.AW(AW)) u_route (
    .req      (mem_req),
    .we       (mem_we),
    .addr     (mem_addr),
    .region   (region),
    .ctrl     (ctrl),
    .sel      (sel),
    .dev_addr (dev_addr),
    .dev_we   (dev_we)
  );

  assign sel_lorom = sel[0];
  assign sel_hirom = sel[1];
  assign sel_ram   = sel[2];
  assign sel_exp   = sel[3];
  assign caps_led  = ctrl.caps;

  memmap_status u_stat (
    .shift   (st_shift),
    .protect (ctrl.protect),
    .expand  (ctrl.expand),
    .cart    (st_cart),
    .anykey  (st_anykey),
    .aux     (st_aux),
    .rx      (st_rx),
    .status  (status)
  );

  assign io_rdata = (io_rd_en && io_addr == STAT_PORT) ? DW'(status) : '0;

  // R1: never two devices at once
  a_r1_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_lorom, sel_hirom, sel_ram, sel_exp}));

  // R1: idle bus drives nothing
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> ({sel_lorom, sel_hirom, sel_ram, sel_exp} == 4'b0 && !dev_we));

  // R3: shadowed writes never reach a device
  a_r3_shadow_wr_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr < 16'h0800 && !ctrl_q[CB_SHADOW_N])
      |-> (!dev_we && !sel_hirom && !sel_lorom));

  // R4: protected region rejects writes
  a_r4_protect_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr >= 16'h4000 && mem_addr < 16'h8000 && ctrl_q[CB_PROTECT])
      |-> !dev_we);

  // R5: expansion offset carries the bank bit
  a_r5_bank_bit: assert property (@(posedge clk) disable iff (!rst_n)
    sel_exp |-> (dev_addr[14] == ctrl_q[CB_BANK]));

  // R6: ROM selects only on reads
  a_r6_rom_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_lorom || sel_hirom) |-> (!mem_we && !dev_we));

  // R7: a control write shows up on the lamp next cycle
  a_r7_ctrl_next: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr_en && io_addr == CTRL_PORT) |=> (caps_led == $past(io_wdata[CB_CAPS])));

  // R9: other ports leave the control value alone
  a_r9_other_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr_en && io_addr == CTRL_PORT) |=> $stable(ctrl_q));

endmodule

// File: tb/sim_memmap_ctrl.sv
module sim_memmap_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr_en = 0, io_rd_en = 0;
  logic [7:0]  io_addr = 0, io_wdata = 0, io_rdata;
  logic        mem_req = 0, mem_we = 0;
  logic [15:0] mem_addr = 0, dev_addr;
  logic        sel_lorom, sel_hirom, sel_ram, sel_exp, dev_we, caps_led;
  logic        st_shift = 0, st_anykey = 0, st_cart = 0, st_aux = 0, st_rx = 0;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] m_ctrl = 8'h00;   // model's view of the control register

  always #(CLK_PERIOD/2) clk = ~clk;

  memmap_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .io_wr_en(io_wr_en), .io_rd_en(io_rd_en),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .sel_lorom(sel_lorom), .sel_hirom(sel_hirom), .sel_ram(sel_ram), .sel_exp(sel_exp),
    .dev_addr(dev_addr), .dev_we(dev_we), .caps_led(caps_led),
    .st_shift(st_shift), .st_anykey(st_anykey), .st_cart(st_cart),
    .st_aux(st_aux), .st_rx(st_rx)
  );

  // Behavioural reference: expected {sel[3:0], dev_addr, dev_we, io_rdata, caps}
  task automatic expect_now(output logic [3:0] e_sel, output logic [15:0] e_addr,
                            output logic e_we, output logic [7:0] e_rd,
                            output string tag);
    int a;
    bit shadow, prot, expn, bank;
    a = int'(mem_addr);
    shadow = (m_ctrl[0] == 1'b0);
    prot = m_ctrl[1]; expn = m_ctrl[2]; bank = m_ctrl[3];
    e_sel = 4'b0; e_addr = 16'h0; e_we = 1'b0;
    tag = "R1";
    if (mem_req) begin
      if (a < 'h800) begin
        tag = "R3";
        if (!mem_we) begin
          e_sel = shadow ? 4'b0010 : 4'b0001;
          e_addr = 16'(a % 2048);
        end
      end else if (a < 'h4000) begin
        tag = "R6"; e_sel = 4'b0100; e_addr = 16'(a); e_we = mem_we;
      end else if (a < 'h8000) begin
        tag = "R4";
        if (!(mem_we && prot)) begin
          e_sel = 4'b0100; e_addr = 16'(a); e_we = mem_we;
        end
      end else if (a < 'hC000) begin
        tag = "R5";
        if (expn) begin
          e_sel = 4'b1000; e_addr = 16'((bank ? 'h4000 : 0) + (a - 'h8000));
        end else begin
          e_sel = 4'b0100; e_addr = 16'(a);
        end
        e_we = mem_we;
      end else begin
        tag = "R6";
        if (!mem_we) begin
          e_sel = 4'b0010; e_addr = 16'(a - 'hC000);
        end
      end
    end
    e_rd = 8'h00;
    if (io_rd_en && io_addr == 8'h03)
      e_rd = {st_rx, ~st_anykey, st_aux, st_anykey, st_cart, m_ctrl[2], m_ctrl[1], st_shift};
  endtask

  // drive at negedge, compare a quarter period later, then advance model
  task automatic step(input string req_tag, input bit rq, input bit we, input logic [15:0] ad,
                      input bit iow = 0, input bit ior = 0,
                      input logic [7:0] ioa = 8'h00, input logic [7:0] iod = 8'h00);
    logic [3:0] e_sel; logic [15:0] e_addr; logic e_we; logic [7:0] e_rd; string tag;
    @(negedge clk);
    mem_req = rq; mem_we = we; mem_addr = ad;
    io_wr_en = iow; io_rd_en = ior; io_addr = ioa; io_wdata = iod;
    #(CLK_PERIOD/4);
    expect_now(e_sel, e_addr, e_we, e_rd, tag);
    vectors++;
    if ({sel_exp, sel_ram, sel_hirom, sel_lorom} !== e_sel || dev_addr !== e_addr ||
        dev_we !== e_we || io_rdata !== e_rd || caps_led !== m_ctrl[5]) begin
      miscompares++;
      $display("FAIL %s/%s addr=%h: got sel=%b a=%h we=%b rd=%h caps=%b exp sel=%b a=%h we=%b rd=%h caps=%b",
               req_tag, tag, ad, {sel_exp, sel_ram, sel_hirom, sel_lorom}, dev_addr, dev_we,
               io_rdata, caps_led, e_sel, e_addr, e_we, e_rd, m_ctrl[5]);
    end
    if (iow && ioa == 8'hFF) m_ctrl = iod;   // R7: lands at the coming edge
  endtask

  task automatic sweep(input string t);
    logic [15:0] pts [10] = '{16'h0000, 16'h07FF, 16'h0800, 16'h3FFF, 16'h4000,
                              16'h7FFF, 16'h8000, 16'hBFFF, 16'hC000, 16'hFFFF};
    foreach (pts[i]) begin
      step(t, 1, 0, pts[i]);
      step(t, 1, 1, pts[i]);
    end
  endtask

  bit done = 0;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R2: reset state, shadow on, boot read from high ROM
    step("R2", 1, 0, 16'h0000);
    step("R1", 0, 1, 16'h2000);
    step("R3", 1, 0, 16'h0123);
    step("R3", 1, 1, 16'h0123);
    sweep("R6");
    // R9: write to another port does nothing
    step("R9", 0, 0, 16'h0, 1, 0, 8'hFE, 8'h2F);
    step("R9", 1, 0, 16'h0400);
    // R7: shadow off written together with an access, boundary both sides
    step("R7", 1, 0, 16'h0400, 1, 0, 8'hFF, 8'h01);
    step("R7", 1, 0, 16'h0400);
    sweep("R3");
    // R4: protect on at the same edge as a protected write
    step("R4", 1, 1, 16'h5000, 1, 0, 8'hFF, 8'h03);
    step("R4", 1, 1, 16'h5000);
    step("R4", 1, 0, 16'h5000);
    // R5: window on, then bank flip at an access
    step("R5", 1, 1, 16'h9ABC, 1, 0, 8'hFF, 8'h05);
    step("R5", 1, 1, 16'h9ABC, 1, 0, 8'hFF, 8'h0F);
    step("R5", 1, 0, 16'h9ABC);
    sweep("R5");
    // R7: caps lamp
    step("R7", 0, 0, 16'h0, 1, 0, 8'hFF, 8'h20);
    step("R7", 1, 0, 16'h8001);
    // R8: status port under several input patterns
    step("R8", 0, 0, 16'h0, 1, 0, 8'hFF, 8'h06);
    for (int p = 0; p < 32; p++) begin
      st_shift = p[0]; st_anykey = p[1]; st_cart = p[2]; st_aux = p[3]; st_rx = p[4];
      step("R8", 0, 0, 16'h0, 0, 1, 8'h03);
    end
    step("R8", 0, 0, 16'h0, 0, 1, 8'hFF);
    step("R8", 0, 0, 16'h0, 0, 0, 8'h03);
    // walk of every control value across region edges
    for (int v = 0; v < 64; v++) begin
      step("R7", 0, 0, 16'h0, 1, 0, 8'hFF, 8'(v));
      sweep("R1");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule